// File: doc/BRIEF.md
# Per-Level Wormhole Output Arbiter

This block controls one output port of a wormhole router that carries several service levels. Each input port presents, per service level, the flit at the head of its queue that is bound for this output. For every level the block keeps three things: a lock flag, the input that owns the level while a packet is in flight, and a round-robin pointer. It also keeps a counter of free slots in the next router's buffer for that level. That counter is loaded with the downstream depth at reset, falls by one for each flit sent and rises by one for each credit that comes back.

Each cycle, each level picks a candidate. A locked level only considers its owner. An unlocked level takes, in round-robin order, an input whose head flit opens a packet. A level is ready when it has a candidate and at least one credit. Among the ready levels, the lowest-numbered one sends. The chosen flit is popped from its input in the same cycle and appears on the registered output one cycle later. When no flit is sent, the output carries an idle flit. The input queues and the routing computation sit outside this block.

Top module: `noc_oport_arb`

## Requirements
- R1: After reset the output carries kind 0 (idle), level 0 and data 0. Every level starts unlocked, with its round-robin pointer at input 0 and its credit count equal to DEPTH.
- R2: Flit kinds are 3-bit codes: 0 idle, 1 head, 2 body, 3 tail, 4 single. Input i, level s uses slot i*NUM_SL+s of in_valid, in_kind (3 bits per slot) and in_data. On an unlocked level, only a head or a single flit can win. Body and tail flits there are not popped.
- R3: On an unlocked level, the winner is the first requesting input found when searching upward from the round-robin pointer, wrapping from NUM_IN-1 to 0.
- R4: Forwarding a head flit locks its level to that input. While the level is locked, only that input's flits on that level are forwarded. If the owner has no flit, the level sends nothing.
- R5: Forwarding a tail flit on a locked level, or a single flit on an unlocked level, leaves the level unlocked. The level's pointer then moves to the input after the one served.
- R6: A level's credit count drops by one for each flit sent on it and rises by one for each cycle its credit_ret bit is high. When both happen in the same cycle, the count is unchanged. No flit is sent on a level whose count is zero.
- R7: At most one flit is popped per cycle. When several levels are ready, the lowest-numbered level sends.
- R8: A flit popped in one cycle appears on out_kind, out_sl and out_data after the next clock edge. A cycle with no pop yields an idle flit with level 0 and data 0.
- R9: Locks are kept per level. A packet locked on one level does not block another input from sending on a different level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_IN*NUM_SL | Head flit present, per input and level |
| in_kind | input | NUM_IN*NUM_SL*3 | Head flit kind, per input and level |
| in_data | input | NUM_IN*NUM_SL*DATA_W | Head flit payload, per input and level |
| credit_ret | input | NUM_SL | One credit returned by the next router, per level |
| in_pop | output | NUM_IN*NUM_SL | Head flit consumed this cycle |
| out_kind | output | 3 | Kind of the forwarded flit (0 when idle) |
| out_sl | output | max(1,clog2(NUM_SL)) | Level of the forwarded flit |
| out_data | output | DATA_W | Payload of the forwarded flit |

## Verification
On every cycle the assertions check the following. No more than one slot is popped. Only valid slots are popped. A locked level pops only its owner. An unlocked level pops only packet-opening flits. No level sends without credit. No credit count goes above its depth. A cycle with no pop is followed by an idle output.

Some behaviour only the directed scenarios can show. These are the exact round-robin order after each release, and the credit count's exact value after sends and returns that overlap. They also cover priority between levels that are ready together, and one level making progress while another sits locked and stalled.

// File: rtl/noc_oport_pkg.sv
package noc_oport_pkg;

    typedef enum logic [2:0] {
        KIND_IDLE   = 3'd0,
        KIND_HEAD   = 3'd1,
        KIND_BODY   = 3'd2,
        KIND_TAIL   = 3'd3,
        KIND_SINGLE = 3'd4
    } flit_kind_e;

    localparam int KIND_W = 3;

    // A flit that may claim an unlocked level.
    function automatic logic opens_packet(input logic [KIND_W-1:0] k);
        return (k == KIND_HEAD) || (k == KIND_SINGLE);
    endfunction

    // A flit after which the level is free again.
    function automatic logic closes_packet(input logic [KIND_W-1:0] k);
        return (k == KIND_TAIL) || (k == KIND_SINGLE);
    endfunction

endpackage

// File: rtl/noc_rr_pick.sv
module noc_rr_pick #(
    parameter int N = 5,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] ptr,
    output logic          found,
    output logic [IW-1:0] idx
);

    int cand;

    // Search upward from the pointer, wrapping once.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        cand  = 0;
        for (int k = 0; k < N; k++) begin
            cand = (int'(ptr) + k) % N;
            if (!found && req[cand]) begin
                found = 1'b1;
                idx   = IW'(cand);
            end
        end
    end

endmodule

// File: rtl/noc_credit_ctr.sv
module noc_credit_ctr #(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          give,
    output logic [CW-1:0] cnt,
    output logic          avail
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (take && !give) begin
            cnt_d = cnt_q - CW'(1);
        end else if (give && !take) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CW'(DEPTH);
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt   = cnt_q;
    assign avail = (cnt_q != '0);

endmodule

// File: rtl/noc_oport_arb.sv
module noc_oport_arb
    import noc_oport_pkg::*;
#(
    parameter int NUM_IN = 5,
    parameter int NUM_SL = 2,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4,
    localparam int IW    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
    localparam int SW    = (NUM_SL > 1) ? $clog2(NUM_SL) : 1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int SLOTS = NUM_IN * NUM_SL
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SLOTS-1:0]           in_valid,
    input  logic [SLOTS*KIND_W-1:0]    in_kind,
    input  logic [SLOTS*DATA_W-1:0]    in_data,
    input  logic [NUM_SL-1:0]          credit_ret,
    output logic [SLOTS-1:0]           in_pop,
    output logic [KIND_W-1:0]          out_kind,
    output logic [SW-1:0]              out_sl,
    output logic [DATA_W-1:0]          out_data
);

    typedef struct packed {
        logic [NUM_SL-1:0]          lock;
        logic [NUM_SL-1:0][IW-1:0]  owner;
        logic [NUM_SL-1:0][IW-1:0]  ptr;
        logic [KIND_W-1:0]          o_kind;
        logic [SW-1:0]              o_sl;
        logic [DATA_W-1:0]          o_data;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SL-1:0][NUM_IN-1:0] head_req;
    logic [NUM_SL-1:0]             pick_found;
    logic [NUM_SL-1:0][IW-1:0]     pick_idx;
    logic [NUM_SL-1:0]             lvl_found;
    logic [NUM_SL-1:0][IW-1:0]     lvl_idx;
    logic [NUM_SL-1:0]             lvl_avail;
    logic [NUM_SL-1:0]             lvl_ready;
    logic [NUM_SL-1:0]             take;
    logic [NUM_SL-1:0][CW-1:0]     credit_cnt;
    logic [NUM_SL-1:0]             lock_q;
    logic [NUM_SL-1:0][IW-1:0]     owner_q;

    function automatic logic [IW-1:0] next_in(input logic [IW-1:0] i);
        return (i == IW'(NUM_IN - 1)) ? '0 : i + IW'(1);
    endfunction

    // Per-level candidate selection and downstream credit tracking.
    for (genvar s = 0; s < NUM_SL; s++) begin : g_lvl
        for (genvar i = 0; i < NUM_IN; i++) begin : g_in
            assign head_req[s][i] = in_valid[i*NUM_SL+s]
                && opens_packet(in_kind[(i*NUM_SL+s)*KIND_W +: KIND_W]);
        end

        noc_rr_pick #(.N(NUM_IN)) i_pick (
            .req   (head_req[s]),
            .ptr   (st_q.ptr[s]),
            .found (pick_found[s]),
            .idx   (pick_idx[s])
        );

        assign lvl_found[s] = st_q.lock[s]
            ? in_valid[int'(st_q.owner[s])*NUM_SL + s]
            : pick_found[s];
        assign lvl_idx[s]   = st_q.lock[s] ? st_q.owner[s] : pick_idx[s];
        assign lvl_ready[s] = lvl_found[s] && lvl_avail[s];

        noc_credit_ctr #(.DEPTH(DEPTH)) i_credit (
            .clk   (clk),
            .rst_n (rst_n),
            .take  (take[s]),
            .give  (credit_ret[s]),
            .cnt   (credit_cnt[s]),
            .avail (lvl_avail[s])
        );
    end

    logic              send;
    logic [SW-1:0]     sel_s;
    logic [IW-1:0]     sel_i;
    logic [KIND_W-1:0] sel_kind;
    int                ent;

    always_comb begin
        st_d        = st_q;
        st_d.o_kind = KIND_IDLE;
        st_d.o_sl   = '0;
        st_d.o_data = '0;
        in_pop      = '0;
        take        = '0;
        send        = 1'b0;
        sel_s       = '0;
        for (int s = 0; s < NUM_SL; s++) begin
            if (!send && lvl_ready[s]) begin
                send  = 1'b1;
                sel_s = SW'(s);
            end
        end
        sel_i    = lvl_idx[sel_s];
        ent      = int'(sel_i) * NUM_SL + int'(sel_s);
        sel_kind = in_kind[ent*KIND_W +: KIND_W];
        if (send) begin
            in_pop[ent] = 1'b1;
            take[sel_s] = 1'b1;
            st_d.o_kind = sel_kind;
            st_d.o_sl   = sel_s;
            st_d.o_data = in_data[ent*DATA_W +: DATA_W];
            if (!st_q.lock[sel_s]) begin
                if (closes_packet(sel_kind)) begin
                    st_d.ptr[sel_s] = next_in(sel_i);
                end else begin
                    st_d.lock[sel_s]  = 1'b1;
                    st_d.owner[sel_s] = sel_i;
                end
            end else if (closes_packet(sel_kind)) begin
                st_d.lock[sel_s] = 1'b0;
                st_d.ptr[sel_s]  = next_in(st_q.owner[sel_s]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lock   <= '0;
            st_q.owner  <= '0;
            st_q.ptr    <= '0;
            st_q.o_kind <= KIND_IDLE;
            st_q.o_sl   <= '0;
            st_q.o_data <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_q   = st_q.lock;
    assign owner_q  = st_q.owner;
    assign out_kind = st_q.o_kind;
    assign out_sl   = st_q.o_sl;
    assign out_data = st_q.o_data;

endmodule

// File: rtl/noc_oport_arb_chk.sv
module noc_oport_arb_chk
    import noc_oport_pkg::*;
#(
    parameter int NUM_IN = 5,
    parameter int NUM_SL = 2,
    parameter int DEPTH  = 4,
    localparam int IW    = (NUM_IN > 1) ? $clog2(NUM_IN) : 1,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int SLOTS = NUM_IN * NUM_SL
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [SLOTS-1:0]          in_valid,
    input logic [SLOTS*KIND_W-1:0]   in_kind,
    input logic [SLOTS-1:0]          in_pop,
    input logic [KIND_W-1:0]         out_kind,
    input logic [NUM_SL-1:0]         lock,
    input logic [NUM_SL-1:0][IW-1:0] owner,
    input logic [NUM_SL-1:0][CW-1:0] cnt
);

    a_r7_one_flit: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_pop));

    a_r2_pop_valid_only: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop & ~in_valid) == '0);

    a_r8_idle_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pop == '0) |=> (out_kind == KIND_IDLE));

    for (genvar s = 0; s < NUM_SL; s++) begin : g_lvl
        logic [NUM_IN-1:0] lvl_pop;
        for (genvar i = 0; i < NUM_IN; i++) begin : g_in
            assign lvl_pop[i] = in_pop[i*NUM_SL+s];

            a_r4_owner_only: assert property (@(posedge clk) disable iff (!rst_n)
                (lock[s] && lvl_pop[i]) |-> (owner[s] == IW'(i)));

            a_r2_opener_only: assert property (@(posedge clk) disable iff (!rst_n)
                (!lock[s] && lvl_pop[i]) |->
                opens_packet(in_kind[(i*NUM_SL+s)*KIND_W +: KIND_W]));
        end

        a_r6_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
            (|lvl_pop) |-> (cnt[s] != '0));

        a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[s] <= CW'(DEPTH));
    end

endmodule

bind noc_oport_arb noc_oport_arb_chk #(
    .NUM_IN (NUM_IN),
    .NUM_SL (NUM_SL),
    .DEPTH  (DEPTH)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_kind  (in_kind),
    .in_pop   (in_pop),
    .out_kind (out_kind),
    .lock     (lock_q),
    .owner    (owner_q),
    .cnt      (credit_cnt)
);

// File: tb/test_noc_oport_arb.sv
module test_noc_oport_arb;

    localparam int CLK_PERIOD = 10;
    localparam int NI = 5;
    localparam int NS = 2;
    localparam int DW = 16;
    localparam int DEPTH = 4;
    localparam int SLOTS = NI * NS;

    localparam logic [2:0] K_IDLE = 3'd0;
    localparam logic [2:0] K_HEAD = 3'd1;
    localparam logic [2:0] K_BODY = 3'd2;
    localparam logic [2:0] K_TAIL = 3'd3;
    localparam logic [2:0] K_SGL  = 3'd4;

    logic               clk;
    logic               rst_n;
    logic [SLOTS-1:0]   in_valid;
    logic [SLOTS*3-1:0] in_kind;
    logic [SLOTS*DW-1:0] in_data;
    logic [NS-1:0]      credit_ret;
    logic [SLOTS-1:0]   in_pop;
    logic [2:0]         out_kind;
    logic [0:0]         out_sl;
    logic [DW-1:0]      out_data;

    logic          v [NI][NS];
    logic [2:0]    k [NI][NS];
    logic [DW-1:0] d [NI][NS];

    int n_chk = 0;
    int n_err = 0;

    always_comb begin
        for (int i = 0; i < NI; i++) begin
            for (int s = 0; s < NS; s++) begin
                in_valid[i*NS+s]        = v[i][s];
                in_kind[(i*NS+s)*3 +: 3] = k[i][s];
                in_data[(i*NS+s)*DW +: DW] = d[i][s];
            end
        end
    end

    noc_oport_arb #(.NUM_IN(NI), .NUM_SL(NS), .DATA_W(DW), .DEPTH(DEPTH)) i_noc_oport_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_kind    (in_kind),
        .in_data    (in_data),
        .credit_ret (credit_ret),
        .in_pop     (in_pop),
        .out_kind   (out_kind),
        .out_sl     (out_sl),
        .out_data   (out_data)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int i, input int s, input logic [2:0] kk, input logic [DW-1:0] dd);
        v[i][s] = 1'b1;
        k[i][s] = kk;
        d[i][s] = dd;
    endtask

    task automatic drop(input int i, input int s);
        v[i][s] = 1'b0;
    endtask

    task automatic clear_inputs();
        for (int i = 0; i < NI; i++) begin
            for (int s = 0; s < NS; s++) begin
                v[i][s] = 1'b0;
                k[i][s] = K_IDLE;
                d[i][s] = '0;
            end
        end
    endtask

    task automatic do_reset();
        clear_inputs();
        credit_ret = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    // One cycle: expect a pop of (exp_i, exp_s) or none (exp_i < 0),
    // then expect that flit (or idle) on the registered output.
    task automatic step(input int exp_i, input int exp_s, input string req);
        logic [SLOTS-1:0] ep;
        logic [2:0]    ek;
        logic [DW-1:0] ed;
        logic [0:0]    es;
        ep = '0;
        ek = K_IDLE;
        ed = '0;
        es = '0;
        #1;
        if (exp_i >= 0) begin
            ep[exp_i*NS+exp_s] = 1'b1;
            ek = k[exp_i][exp_s];
            ed = d[exp_i][exp_s];
            es = 1'(exp_s);
        end
        chk(in_pop == ep, req, "in_pop", longint'(in_pop), longint'(ep));
        @(posedge clk);
        #1;
        chk(out_kind == ek && out_sl == es && out_data == ed, "R8", "out kind/sl/data",
            longint'({out_kind, out_sl, out_data}), longint'({ek, es, ed}));
    endtask

    task automatic t_reset();
        do_reset();
        chk(out_kind == K_IDLE && out_sl == '0 && out_data == '0, "R1", "out after reset",
            longint'({out_kind, out_sl, out_data}), 0);
        step(-1, 0, "R1");
    endtask

    task automatic t_ignore();
        do_reset();
        put(2, 0, K_BODY, 16'h0201);
        step(-1, 0, "R2");
        put(2, 0, K_TAIL, 16'h0202);
        put(3, 1, K_BODY, 16'h0301);
        step(-1, 0, "R2");
        drop(3, 1);
        put(2, 0, K_HEAD, 16'h0203);
        step(2, 0, "R2");
        drop(2, 0);
    endtask

    task automatic t_round_robin();
        do_reset();
        put(3, 0, K_SGL, 16'h3a01);
        step(3, 0, "R3");
        put(3, 0, K_SGL, 16'h3a02);
        put(4, 0, K_SGL, 16'h4a01);
        step(4, 0, "R3");
        drop(4, 0);
        put(1, 0, K_SGL, 16'h1a01);
        step(1, 0, "R3");
        drop(1, 0);
        step(3, 0, "R5");
        drop(3, 0);
    endtask

    task automatic t_lock_credit();
        do_reset();
        put(0, 1, K_HEAD, 16'hb001);
        step(0, 1, "R4");
        put(0, 1, K_BODY, 16'hb002);
        put(2, 1, K_HEAD, 16'hb201);
        step(0, 1, "R4");
        drop(0, 1);
        step(-1, 0, "R4");
        put(0, 1, K_TAIL, 16'hb003);
        step(0, 1, "R5");
        drop(0, 1);
        step(2, 1, "R5");
        put(2, 1, K_TAIL, 16'hb202);
        step(-1, 0, "R6");
        credit_ret[1] = 1'b1;
        step(-1, 0, "R6");
        credit_ret[1] = 1'b0;
        step(2, 1, "R6");
        drop(2, 1);
        put(1, 1, K_SGL, 16'hb101);
        step(-1, 0, "R6");
        drop(1, 1);
    endtask

    task automatic t_credit_overlap();
        do_reset();
        credit_ret[0] = 1'b1;
        for (int n = 0; n < 3; n++) begin
            put(0, 0, K_SGL, 16'hc000 + 16'(n));
            step(0, 0, "R6");
        end
        credit_ret[0] = 1'b0;
        for (int n = 0; n < DEPTH; n++) begin
            put(0, 0, K_SGL, 16'hc100 + 16'(n));
            step(0, 0, "R6");
        end
        step(-1, 0, "R6");
        drop(0, 0);
    endtask

    task automatic t_priority();
        do_reset();
        put(1, 0, K_SGL, 16'hd100);
        put(3, 1, K_SGL, 16'hd301);
        step(1, 0, "R7");
        drop(1, 0);
        step(3, 1, "R7");
        drop(3, 1);
        step(-1, 0, "R7");
    endtask

    task automatic t_independent();
        do_reset();
        put(4, 0, K_HEAD, 16'he401);
        step(4, 0, "R9");
        drop(4, 0);
        put(0, 1, K_SGL, 16'he001);
        put(2, 0, K_HEAD, 16'he201);
        step(0, 1, "R9");
        drop(0, 1);
        step(-1, 0, "R9");
        put(4, 0, K_TAIL, 16'he402);
        step(4, 0, "R9");
        drop(4, 0);
        step(2, 0, "R9");
        drop(2, 0);
    endtask

    initial begin
        rst_n = 1'b0;
        credit_ret = '0;
        clear_inputs();
        t_reset();
        t_ignore();
        t_round_robin();
        t_lock_credit();
        t_credit_overlap();
        t_priority();
        t_independent();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule